// File: doc/BRIEF.md
# Fault Escalation and Shutdown Controller

This controller watches the protection faults reported while one instruction runs or while one exception handler is being entered. The first fault selects that fault's own vector. A second fault before the count is cleared is promoted to the double-fault vector, and that vector always carries an all-zero error code. A further fault while the double-fault handler is being entered moves the controller into shutdown. In shutdown, instruction fetch and exception processing are blocked, and a single-cycle request for a halt-type bus cycle tells the outside world that shutdown has begun.

Shutdown can be left in two ways. An NMI starts a recovery entry. If that entry completes cleanly, the controller returns to normal operation and the protected-mode flag is kept. If the recovery entry fails, the controller goes back into shutdown and ignores every later NMI. Only the RESET input can then release it, and RESET also clears protected mode. Every pin of the block is a plain control or status strobe. No data stream crosses its edge, so it has no valid/ready handshake. Each strobe is sampled on the rising clock edge, and every output is a register or is decoded from the state register.

Top module: `fault_escalation_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the controller returns to its normal state after that edge: `shutdown_o`, `halt_req_o`, `vec_valid_o`, `err_zero_o` and `pm_o` are all 0.
- R2: In the normal state, `fault_i` causes a fault entry after the next edge: `vec_valid_o`=1, `vec_o` equals the `fault_vec_i` value sampled at that edge, and `err_zero_o`=0.
- R3: `fault_i` during a fault entry causes a double-fault entry after the next edge: `vec_o`=8 and `err_zero_o`=1.
- R4: During a fault entry or a double-fault entry, `insn_done_i` or `entry_done_i` without `fault_i` clears the fault count, and `vec_valid_o` drops to 0. When `fault_i` arrives in the same cycle as `insn_done_i` or `entry_done_i`, `fault_i` takes priority. The fault after a clear is treated as a first fault and gets its own vector.
- R5: `fault_i` during a double-fault entry makes `shutdown_o` 1 after the next edge.
- R6: `halt_req_o` is high for exactly one cycle on each entry into shutdown. That cycle is the first cycle in which `shutdown_o` is 1.
- R7: In shutdown, `fault_i`, `insn_done_i` and `entry_done_i` have no effect: `shutdown_o` stays 1, and `vec_valid_o` and `halt_req_o` stay 0.
- R8: `nmi_i` in shutdown starts a recovery entry after the next edge: `shutdown_o`=0, `vec_valid_o`=1 and `vec_o`=2. A following `entry_done_i` returns the controller to the normal state.
- R9: `nmi_err_i` or `fault_i` during a recovery entry puts the controller back into shutdown, with a new `halt_req_o` pulse. After that, `nmi_i` is ignored until reset.
- R10: `pm_enter_i` sets `pm_o` after the next edge. `pm_o` then holds through shutdown and through a recovery by NMI, and only `rst_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous RESET, active high; clears protected mode |
| fault_i | input | 1 | Protection-fault strobe |
| fault_vec_i | input | VEC_W | Vector that the reported fault would use on its own |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| entry_done_i | input | 1 | Handler entry completed strobe |
| nmi_i | input | 1 | Non-maskable interrupt request |
| nmi_err_i | input | 1 | Error during NMI entry |
| pm_enter_i | input | 1 | Sets the protected-mode flag |
| vec_o | output | VEC_W | Selected handler vector |
| vec_valid_o | output | 1 | A handler entry is in progress and `vec_o` is meaningful |
| err_zero_o | output | 1 | The error code pushed for this entry must be zero |
| shutdown_o | output | 1 | Shutdown: fetch and exception processing blocked |
| halt_req_o | output | 1 | One-cycle request for a halt-type bus cycle |
| pm_o | output | 1 | Protected-mode flag |

## Verification
Every result comes one clock edge after the strobe that causes it. Vector, error-code flag, shutdown, halt request and protected-mode flag all change on the edge that samples the stimulus. The bench therefore drives each stimulus on a falling edge, lets exactly one rising edge pass, and reads the outputs on the following falling edge. To confirm that the halt request is a single-cycle pulse, the bench reads it again after one more idle edge. For each of sixteen first-fault vectors, the bench walks the full chain from fault to double fault to shutdown and then checks that the shutdown state holds.

// File: rtl/fesc_pkg.sv
package fesc_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_FAULT,
    ST_DOUBLE,
    ST_SHUT,
    ST_NMI
  } fesc_state_e;
endpackage

// File: rtl/fesc_state.sv
module fesc_state
  import fesc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_i,
  input  logic        fault_i,
  input  logic        insn_done_i,
  input  logic        entry_done_i,
  input  logic        nmi_i,
  input  logic        nmi_err_i,
  output fesc_state_e state_q,
  output fesc_state_e state_d
);
  logic lock_q, lock_d;

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    unique case (state_q)
      ST_NORMAL: if (fault_i) state_d = ST_FAULT;
      ST_FAULT: begin
        if (fault_i) state_d = ST_DOUBLE;
        else if (insn_done_i || entry_done_i) state_d = ST_NORMAL;
      end
      ST_DOUBLE: begin
        if (fault_i) state_d = ST_SHUT;
        else if (insn_done_i || entry_done_i) state_d = ST_NORMAL;
      end
      ST_SHUT: if (nmi_i && !lock_q) state_d = ST_NMI;
      ST_NMI: begin
        if (fault_i || nmi_err_i) begin
          state_d = ST_SHUT;
          lock_d  = 1'b1;
        end else if (entry_done_i) begin
          state_d = ST_NORMAL;
        end
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state_q <= ST_NORMAL;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  // R5
  double_to_shut_chk: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_DOUBLE && fault_i) |=> (state_q == ST_SHUT));

  // R7
  shut_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_SHUT && !nmi_i) |=> (state_q == ST_SHUT));

  // R9
  shut_lock_chk: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_SHUT && lock_q) |=> (state_q == ST_SHUT));
endmodule

// File: rtl/fesc_vector.sv
module fesc_vector
  import fesc_pkg::*;
#(
  parameter int unsigned     VEC_W   = 8,
  parameter logic [VEC_W-1:0] DF_VEC  = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  fesc_state_e      state_q,
  input  fesc_state_e      state_d,
  input  logic [VEC_W-1:0] fault_vec_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             err_zero_o,
  output logic             vec_valid_o
);
  logic [VEC_W-1:0] vec_q;
  logic             ez_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      vec_q <= '0;
      ez_q  <= 1'b0;
    end else if (state_d != state_q) begin
      unique case (state_d)
        ST_FAULT: begin
          vec_q <= fault_vec_i;
          ez_q  <= 1'b0;
        end
        ST_DOUBLE: begin
          vec_q <= DF_VEC;
          ez_q  <= 1'b1;
        end
        ST_NMI: begin
          vec_q <= NMI_VEC;
          ez_q  <= 1'b0;
        end
        default: ez_q <= 1'b0;
      endcase
    end
  end

  assign vec_o       = vec_q;
  assign err_zero_o  = ez_q;
  assign vec_valid_o = (state_q == ST_FAULT) || (state_q == ST_DOUBLE) || (state_q == ST_NMI);

  // R3
  err_zero_vec_chk: assert property (@(posedge clk) disable iff (rst_i)
    err_zero_o |-> (vec_o == DF_VEC && state_q == ST_DOUBLE));
endmodule

// File: rtl/fesc_halt.sv
module fesc_halt
  import fesc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_i,
  input  fesc_state_e state_q,
  input  fesc_state_e state_d,
  output logic        halt_o
);
  logic halt_q;

  always_ff @(posedge clk) begin
    if (rst_i) halt_q <= 1'b0;
    else       halt_q <= (state_d == ST_SHUT) && (state_q != ST_SHUT);
  end

  assign halt_o = halt_q;

  // R6
  halt_one_shot_chk: assert property (@(posedge clk) disable iff (rst_i)
    halt_q |=> !halt_q);
endmodule

// File: rtl/fault_escalation_ctrl.sv
module fault_escalation_ctrl
  import fesc_pkg::*;
#(
  parameter int unsigned      VEC_W   = 8,
  parameter logic [VEC_W-1:0] DF_VEC  = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             fault_i,
  input  logic [VEC_W-1:0] fault_vec_i,
  input  logic             insn_done_i,
  input  logic             entry_done_i,
  input  logic             nmi_i,
  input  logic             nmi_err_i,
  input  logic             pm_enter_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             err_zero_o,
  output logic             shutdown_o,
  output logic             halt_req_o,
  output logic             pm_o
);
  fesc_state_e state_q, state_d;
  logic        pm_q;

  fesc_state state_i (
    .clk          (clk),
    .rst_i        (rst_i),
    .fault_i      (fault_i),
    .insn_done_i  (insn_done_i),
    .entry_done_i (entry_done_i),
    .nmi_i        (nmi_i),
    .nmi_err_i    (nmi_err_i),
    .state_q      (state_q),
    .state_d      (state_d)
  );

  fesc_vector #(
    .VEC_W   (VEC_W),
    .DF_VEC  (DF_VEC),
    .NMI_VEC (NMI_VEC)
  ) vector_i (
    .clk         (clk),
    .rst_i       (rst_i),
    .state_q     (state_q),
    .state_d     (state_d),
    .fault_vec_i (fault_vec_i),
    .vec_o       (vec_o),
    .err_zero_o  (err_zero_o),
    .vec_valid_o (vec_valid_o)
  );

  fesc_halt halt_i (
    .clk     (clk),
    .rst_i   (rst_i),
    .state_q (state_q),
    .state_d (state_d),
    .halt_o  (halt_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst_i)           pm_q <= 1'b0;
    else if (pm_enter_i) pm_q <= 1'b1;
  end

  assign pm_o       = pm_q;
  assign shutdown_o = (state_q == ST_SHUT);

  // R6
  halt_in_shut_chk: assert property (@(posedge clk) disable iff (rst_i)
    halt_req_o |-> shutdown_o);

  // R10
  pm_keep_chk: assert property (@(posedge clk) disable iff (rst_i)
    pm_o |=> pm_o);

  // R2
  first_fault_vec_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!shutdown_o && !vec_valid_o && fault_i) |=> (vec_valid_o && vec_o == $past(fault_vec_i)));
endmodule

// File: tb/fault_escalation_ctrl_tb_top.sv
module fault_escalation_ctrl_tb_top;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_i, fault_i, insn_done_i, entry_done_i, nmi_i, nmi_err_i, pm_enter_i;
  logic [VW-1:0] fault_vec_i;
  logic [VW-1:0] vec_o;
  logic          vec_valid_o, err_zero_o, shutdown_o, halt_req_o, pm_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fault_escalation_ctrl #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst_i(rst_i), .fault_i(fault_i), .fault_vec_i(fault_vec_i),
    .insn_done_i(insn_done_i), .entry_done_i(entry_done_i), .nmi_i(nmi_i),
    .nmi_err_i(nmi_err_i), .pm_enter_i(pm_enter_i), .vec_o(vec_o),
    .vec_valid_o(vec_valid_o), .err_zero_o(err_zero_o), .shutdown_o(shutdown_o),
    .halt_req_o(halt_req_o), .pm_o(pm_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rst_i = 0; fault_i = 0; insn_done_i = 0; entry_done_i = 0;
    nmi_i = 0; nmi_err_i = 0; pm_enter_i = 0; fault_vec_i = '0;
  endtask

  // Inputs set here are seen at one rising edge; results read on the next falling edge.
  task automatic cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_i = 1; cyc();
  endtask

  task automatic do_fault(input int v);
    fault_i = 1; fault_vec_i = VW'(v); cyc();
  endtask

  task automatic to_shutdown();
    do_fault(3); do_fault(4); do_fault(5);
  endtask

  initial begin
    idle_inputs();
    rst_i = 1;
    @(negedge clk); @(negedge clk);
    rst_i = 0;
    // R1 reset state
    chk("R1", "shutdown", shutdown_o, 0);
    chk("R1", "halt", halt_req_o, 0);
    chk("R1", "valid", vec_valid_o, 0);
    chk("R1", "err_zero", err_zero_o, 0);
    chk("R1", "pm", pm_o, 0);

    for (int v = 0; v < 16; v++) begin
      do_reset();
      do_fault(v);
      chk("R2", "vec", vec_o, v);
      chk("R2", "valid", vec_valid_o, 1);
      chk("R2", "err_zero", err_zero_o, 0);
      if (v % 2 == 1) begin
        // R4 fault wins over a simultaneous completion
        fault_i = 1; entry_done_i = 1; insn_done_i = (v % 4 == 3); cyc();
      end else begin
        do_fault(v + 1);
      end
      chk("R3", "vec", vec_o, 8);
      chk("R3", "err_zero", err_zero_o, 1);
      do_fault(v);
      chk("R5", "shutdown", shutdown_o, 1);
      chk("R6", "halt first", halt_req_o, 1);
      cyc();
      chk("R6", "halt second", halt_req_o, 0);
      fault_i = 1; insn_done_i = 1; entry_done_i = 1; cyc();
      chk("R7", "shutdown", shutdown_o, 1);
      chk("R7", "valid", vec_valid_o, 0);
      chk("R7", "halt", halt_req_o, 0);
    end

    // R4 clearing by boundary and by clean entry completion
    do_reset();
    do_fault(5);
    insn_done_i = 1; cyc();
    chk("R4", "valid after boundary", vec_valid_o, 0);
    do_fault(6);
    chk("R4", "vec after boundary", vec_o, 6);
    entry_done_i = 1; cyc();
    chk("R4", "valid after entry", vec_valid_o, 0);
    do_fault(7);
    chk("R4", "vec after entry", vec_o, 7);
    chk("R4", "err_zero after entry", err_zero_o, 0);
    do_fault(1);
    insn_done_i = 1; cyc();
    chk("R4", "double cleared", vec_valid_o, 0);
    chk("R4", "no shutdown", shutdown_o, 0);

    // R8 / R10 recovery through NMI
    do_reset();
    pm_enter_i = 1; cyc();
    chk("R10", "pm set", pm_o, 1);
    to_shutdown();
    chk("R10", "pm in shutdown", pm_o, 1);
    nmi_i = 1; cyc();
    chk("R8", "shutdown", shutdown_o, 0);
    chk("R8", "vec", vec_o, 2);
    chk("R8", "valid", vec_valid_o, 1);
    entry_done_i = 1; cyc();
    chk("R8", "valid after entry", vec_valid_o, 0);
    chk("R8", "shutdown after entry", shutdown_o, 0);
    chk("R10", "pm kept", pm_o, 1);
    do_fault(9);
    chk("R8", "fresh fault vec", vec_o, 9);

    // R9 failed recovery, NMI then ignored
    to_shutdown();
    nmi_i = 1; cyc();
    nmi_err_i = 1; cyc();
    chk("R9", "shutdown again", shutdown_o, 1);
    chk("R9", "halt again", halt_req_o, 1);
    cyc();
    chk("R9", "halt drops", halt_req_o, 0);
    nmi_i = 1; cyc();
    chk("R9", "nmi ignored", shutdown_o, 1);
    chk("R9", "nmi no vec", vec_valid_o, 0);
    do_reset();
    chk("R10", "pm cleared", pm_o, 0);
    chk("R1", "shutdown cleared", shutdown_o, 0);

    // R9 fault during recovery
    to_shutdown();
    nmi_i = 1; cyc();
    do_fault(2);
    chk("R9", "fault in recovery", shutdown_o, 1);
    chk("R9", "fault halt", halt_req_o, 1);
    nmi_i = 1; cyc();
    chk("R9", "locked", shutdown_o, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule